// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Mode Controller

This block sits beside the command decoder of a synchronous DRAM and decides, on every rising clock edge, which power mode the device occupies. It looks at the clock-enable level sampled at the present edge and at the one before it, at the decoded command registered at the same edge, and at two state flags from the bank logic: whether every bank is idle and whether a read or write burst is in progress. From these it moves among four modes: normal running, power-down, self refresh and clock suspend.

The block drives an internal clock-gate enable that switches off the core clock in every low-power mode. It also raises a ready flag that tells the decoder when ordinary commands may be taken. After leaving self refresh, the block holds ready low through a recovery window. That window ends only when a minimum number of edges have passed and a minimum number of NOP commands have been registered. Any real command issued inside the window sets a sticky protocol-error flag. The self-refresh residency floor, the recovery length and the required NOP count are parameters given in clock cycles.

Top module: `sdram_pwr_mode_ctl`

## Requirements
- R1: During and directly after reset, `pwr_mode` is 0 (normal), `clk_gate_en` is 1, `cmd_ready` is 1 and `proto_err` is 0.
- R2: With `cmd_ready` high, an edge where `cke_prev`=1 and `cke_cur`=0, `banks_idle`=1, `burst_active`=0 and `cmd` equal to NOP (code 0) or INHIBIT (code 1) moves `pwr_mode` to 1 (power-down) after that edge.
- R3: The same edge with `cmd` equal to REFRESH (code 6) moves `pwr_mode` to 2 (self refresh).
- R4: A falling clock enable (`cke_prev`=1, `cke_cur`=0) with `burst_active`=1 moves `pwr_mode` to 3 (clock suspend), whatever `banks_idle` and `cmd` are.
- R5: A falling clock enable with no burst and either `banks_idle`=0 or a command other than codes 0, 1 and 6 leaves `pwr_mode` at 0.
- R6: While `cke_cur` is 0, power-down, self refresh and clock suspend each hold their mode.
- R7: From power-down or clock suspend, an edge with `cke_cur`=1 returns `pwr_mode` to 0 with `cmd_ready` high right after that edge.
- R8: Self refresh is left only at an edge with `cke_cur`=1 that is at least TRAS_CYC edges after the entry edge; an earlier high clock enable keeps the mode at 2.
- R9: In self refresh, `cmd`, `banks_idle`, `burst_active` and `cke_prev` have no effect on any output.
- R10: After self-refresh exit, `pwr_mode` is 0 but `cmd_ready` stays low until at least TXSR_CYC edges have passed and at least MIN_EXIT_NOPS NOP commands (code 0) have been registered in the window; with the default variant, INHIBIT (code 1) is allowed but not counted.
- R11: A command with code 2 to 7 registered while the recovery window is open sets `proto_err`, which then stays high until reset.
- R12: `clk_gate_en` is 0 in modes 1, 2 and 3 and 1 in mode 0, including during the recovery window.
- R13: While `cmd_ready` is low, a falling clock enable does not start any low-power mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock-enable level sampled at the previous edge |
| cke_cur | input | 1 | Clock-enable level sampled at this edge |
| cmd | input | 3 | Decoded command: 0 NOP, 1 INHIBIT, 2 ACTIVE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 REFRESH, 7 MODE LOAD |
| banks_idle | input | 1 | All banks are precharged and idle |
| burst_active | input | 1 | A read or write burst is in progress |
| pwr_mode | output | 2 | 0 normal, 1 power-down, 2 self refresh, 3 clock suspend |
| clk_gate_en | output | 1 | Enable for the internal core clock gate |
| cmd_ready | output | 1 | Ordinary commands are accepted |
| proto_err | output | 1 | Sticky flag for a forbidden command in the recovery window |

## Verification
The checker watches, on every cycle, that low-power modes hold while clock enable stays low, that a burst with a falling clock enable always lands in clock suspend, that self refresh is never left before its residency floor, that ready is low at the first cycle after self-refresh exit, and that the error flag never clears. Which code pushes the mode into power-down rather than self refresh, and the exact cycle at which ready returns given a mix of NOP and INHIBIT in the window, can only be shown by the bench's scenarios. These scenarios pair directed sequences with random streams and compare the outputs against a cycle model.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_PDN  = 2'd1,
      PM_SREF = 2'd2,
      PM_SUSP = 2'd3
   } pwr_mode_t;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_INH   = 3'd1,
      CMD_ACT   = 3'd2,
      CMD_RD    = 3'd3,
      CMD_WR    = 3'd4,
      CMD_PRE   = 3'd5,
      CMD_REF   = 3'd6,
      CMD_MRS   = 3'd7
   } dram_cmd_t;

   function automatic logic is_idle_cmd(input dram_cmd_t c);
      return (c == CMD_NOP) || (c == CMD_INH);
   endfunction

endpackage

// File: rtl/sdram_pwr_mode_fsm.sv
module sdram_pwr_mode_fsm
   import sdram_pwr_pkg::*;
#(
   parameter int TRAS_CYC = 5
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cke_prev,
   input  logic      cke_cur,
   input  dram_cmd_t cmd,
   input  logic      banks_idle,
   input  logic      burst_active,
   input  logic      entry_ok,
   output pwr_mode_t mode,
   output logic      sref_exit
);

   localparam int RW = $clog2(TRAS_CYC + 2);
   localparam logic [RW-1:0] RES_MIN = RW'(TRAS_CYC);

   pwr_mode_t     mode_q, mode_d;
   logic [RW-1:0] res_q, res_d;
   logic          falling;

   assign falling = cke_prev && !cke_cur;

   always_comb begin
      mode_d    = mode_q;
      res_d     = res_q;
      sref_exit = 1'b0;
      unique case (mode_q)
         PM_RUN: begin
            if (entry_ok && falling) begin
               if (burst_active) begin
                  mode_d = PM_SUSP;
               end else if (banks_idle && cmd == CMD_REF) begin
                  mode_d = PM_SREF;
                  res_d  = RW'(1);
               end else if (banks_idle && is_idle_cmd(cmd)) begin
                  mode_d = PM_PDN;
               end
            end
         end
         PM_PDN, PM_SUSP: begin
            if (cke_cur) mode_d = PM_RUN;
         end
         PM_SREF: begin
            if (cke_cur && res_q >= RES_MIN) begin
               mode_d    = PM_RUN;
               sref_exit = 1'b1;
            end else if (res_q < RES_MIN) begin
               res_d = res_q + RW'(1);
            end
         end
         default: mode_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= PM_RUN;
         res_q  <= '0;
      end else begin
         mode_q <= mode_d;
         res_q  <= res_d;
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/sdram_sref_exit_win.sv
module sdram_sref_exit_win
   import sdram_pwr_pkg::*;
#(
   parameter int TXSR_CYC      = 4,
   parameter int MIN_EXIT_NOPS = 2,
   parameter bit NOP_ONLY_CNT  = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  dram_cmd_t cmd,
   output logic      busy,
   output logic      err
);

   localparam int XW = $clog2(TXSR_CYC + 2);
   localparam int NW = $clog2(MIN_EXIT_NOPS + 2);
   localparam logic [XW-1:0] X_MAX = XW'(TXSR_CYC);
   localparam logic [NW-1:0] N_MAX = NW'(MIN_EXIT_NOPS);

   logic [XW-1:0] cyc_q, cyc_d;
   logic [NW-1:0] nop_q, nop_d;
   logic          busy_q, err_q;
   logic          counted;

   generate
      if (NOP_ONLY_CNT) begin : g_nop_only
         assign counted = (cmd == CMD_NOP);
      end else begin : g_nop_or_inh
         assign counted = is_idle_cmd(cmd);
      end
   endgenerate

   always_comb begin
      cyc_d = (cyc_q >= X_MAX) ? cyc_q : cyc_q + XW'(1);
      nop_d = (nop_q >= N_MAX || !counted) ? nop_q : nop_q + NW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         cyc_q  <= '0;
         nop_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cyc_q  <= '0;
         nop_q  <= '0;
      end else if (busy_q) begin
         cyc_q <= cyc_d;
         nop_q <= nop_d;
         if (!is_idle_cmd(cmd)) err_q <= 1'b1;
         if (cyc_d >= X_MAX && nop_d >= N_MAX) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign err  = err_q;

endmodule

// File: rtl/sdram_pwr_mode_ctl.sv
module sdram_pwr_mode_ctl
   import sdram_pwr_pkg::*;
#(
   parameter int TRAS_CYC      = 5,
   parameter int TXSR_CYC      = 4,
   parameter int MIN_EXIT_NOPS = 2,
   parameter bit NOP_ONLY_CNT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke_prev,
   input  logic       cke_cur,
   input  logic [2:0] cmd,
   input  logic       banks_idle,
   input  logic       burst_active,
   output logic [1:0] pwr_mode,
   output logic       clk_gate_en,
   output logic       cmd_ready,
   output logic       proto_err
);

   generate
      if (TRAS_CYC < 1) begin : g_bad_tras
         $error("TRAS_CYC must be at least 1");
      end
      if (TXSR_CYC < 1) begin : g_bad_txsr
         $error("TXSR_CYC must be at least 1");
      end
      if (MIN_EXIT_NOPS < 1) begin : g_bad_nops
         $error("MIN_EXIT_NOPS must be at least 1");
      end
   endgenerate

   dram_cmd_t cmd_t;
   pwr_mode_t mode;
   logic      sref_exit;
   logic      win_busy;
   logic      ready;

   assign cmd_t = dram_cmd_t'(cmd);
   assign ready = (mode == PM_RUN) && !win_busy;

   sdram_pwr_mode_fsm #(
      .TRAS_CYC (TRAS_CYC)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke_prev     (cke_prev),
      .cke_cur      (cke_cur),
      .cmd          (cmd_t),
      .banks_idle   (banks_idle),
      .burst_active (burst_active),
      .entry_ok     (ready),
      .mode         (mode),
      .sref_exit    (sref_exit)
   );

   sdram_sref_exit_win #(
      .TXSR_CYC      (TXSR_CYC),
      .MIN_EXIT_NOPS (MIN_EXIT_NOPS),
      .NOP_ONLY_CNT  (NOP_ONLY_CNT)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sref_exit),
      .cmd   (cmd_t),
      .busy  (win_busy),
      .err   (proto_err)
   );

   assign pwr_mode    = mode;
   assign clk_gate_en = (mode == PM_RUN);
   assign cmd_ready   = ready;

endmodule

// File: rtl/sdram_pwr_mode_ctl_chk.sv
module sdram_pwr_mode_ctl_chk #(
   parameter int TRAS_CYC = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke_prev,
   input logic       cke_cur,
   input logic       burst_active,
   input logic [1:0] pwr_mode,
   input logic       clk_gate_en,
   input logic       cmd_ready,
   input logic       proto_err
);

   localparam int CW = $clog2(TRAS_CYC + 2);
   logic [CW-1:0] stay_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) stay_cnt <= '0;
      else if (pwr_mode == 2'd2) begin
         if (stay_cnt < CW'(TRAS_CYC)) stay_cnt <= stay_cnt + CW'(1);
      end else stay_cnt <= '0;
   end

   // R6
   low_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode != 2'd0 && !cke_cur) |=> $stable(pwr_mode));

   // R4
   burst_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && cke_prev && !cke_cur && burst_active) |=> (pwr_mode == 2'd3));

   // R8
   sref_residency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_mode) == 2'd2 && pwr_mode != 2'd2) |-> (stay_cnt >= CW'(TRAS_CYC)));

   // R10
   exit_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_mode) == 2'd2 && pwr_mode == 2'd0) |-> !cmd_ready);

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proto_err) |-> proto_err);

   // R12
   ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> clk_gate_en);

endmodule

bind sdram_pwr_mode_ctl sdram_pwr_mode_ctl_chk #(
   .TRAS_CYC (TRAS_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cke_prev     (cke_prev),
   .cke_cur      (cke_cur),
   .burst_active (burst_active),
   .pwr_mode     (pwr_mode),
   .clk_gate_en  (clk_gate_en),
   .cmd_ready    (cmd_ready),
   .proto_err    (proto_err)
);

// File: tb/sdram_pwr_mode_ctl_bench.sv
module sdram_pwr_mode_ctl_bench;

   localparam int TRAS = 5;
   localparam int TXSR = 4;
   localparam int NOPS = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cke_prev, cke_cur;
   logic [2:0] cmd;
   logic       banks_idle, burst_active;
   logic [1:0] pwr_mode;
   logic       clk_gate_en, cmd_ready, proto_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int e_mode, e_res, e_busy, e_cyc, e_nop, e_err;
   logic cke_last;

   always #10 clk = ~clk;

   sdram_pwr_mode_ctl #(
      .TRAS_CYC (TRAS), .TXSR_CYC (TXSR), .MIN_EXIT_NOPS (NOPS), .NOP_ONLY_CNT (1'b1)
   ) u_sdram_pwr_mode_ctl (
      .clk (clk), .rst_n (rst_n), .cke_prev (cke_prev), .cke_cur (cke_cur),
      .cmd (cmd), .banks_idle (banks_idle), .burst_active (burst_active),
      .pwr_mode (pwr_mode), .clk_gate_en (clk_gate_en),
      .cmd_ready (cmd_ready), .proto_err (proto_err)
   );

   function automatic logic exp_ready();
      return (e_mode == 0) && (e_busy == 0);
   endfunction

   task automatic check(input string tag);
      logic er, eg;
      er = exp_ready();
      eg = (e_mode == 0);
      n_vec++;
      if (pwr_mode !== 2'(e_mode) || cmd_ready !== er || clk_gate_en !== eg
          || proto_err !== e_err[0]) begin
         n_bad++;
         $display("FAIL %s: mode/gate/ready/err got %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                  tag, pwr_mode, clk_gate_en, cmd_ready, proto_err,
                  e_mode, eg, er, e_err[0]);
      end
   endtask

   task automatic model(input logic pv, input logic c, input int cm,
                        input logic id, input logic bu);
      int nm;
      logic rdy, start;
      rdy   = exp_ready();
      nm    = e_mode;
      start = 1'b0;
      case (e_mode)
         0: if (rdy && pv && !c) begin
               if (bu) nm = 3;
               else if (id && cm == 6) begin nm = 2; e_res = 1; end
               else if (id && (cm == 0 || cm == 1)) nm = 1;
            end
         1, 3: if (c) nm = 0;
         default: begin
            if (c && e_res >= TRAS) begin nm = 0; start = 1'b1; end
            else if (e_res < TRAS) e_res++;
         end
      endcase
      if (start) begin
         e_busy = 1; e_cyc = 0; e_nop = 0;
      end else if (e_busy != 0) begin
         if (e_cyc < TXSR) e_cyc++;
         if (cm == 0 && e_nop < NOPS) e_nop++;
         if (cm > 1) e_err = 1;
         if (e_cyc >= TXSR && e_nop >= NOPS) e_busy = 0;
      end
      e_mode = nm;
   endtask

   task automatic step(input logic c, input int cm, input logic id,
                       input logic bu, input string tag);
      cke_prev     = cke_last;
      cke_cur      = c;
      cmd          = 3'(cm);
      banks_idle   = id;
      burst_active = bu;
      model(cke_last, c, cm, id, bu);
      @(posedge clk);
      @(negedge clk);
      cke_last = c;
      check(tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cke_prev = 1'b1; cke_cur = 1'b1; cmd = 3'd0;
      banks_idle = 1'b1; burst_active = 1'b0;
      cke_last = 1'b1;
      e_mode = 0; e_res = 0; e_busy = 0; e_cyc = 0; e_nop = 0; e_err = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1");
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      do_reset();
      step(1, 0, 1, 0, "R1");

      // power-down via NOP, hold, exit
      step(0, 0, 1, 0, "R2/R12");
      step(0, 2, 0, 1, "R6");
      step(0, 6, 1, 0, "R6");
      step(1, 2, 0, 0, "R7");
      // power-down via INHIBIT
      step(1, 0, 1, 0, "R7");
      step(0, 1, 1, 0, "R2");
      step(1, 0, 1, 0, "R7");

      // clock suspend has priority over idle
      step(1, 3, 0, 1, "R4");
      step(0, 0, 1, 1, "R4/R12");
      step(0, 3, 0, 1, "R6");
      step(1, 0, 0, 1, "R7");

      // falling enable without entry conditions
      step(1, 0, 1, 0, "R5");
      step(0, 2, 1, 0, "R5");
      step(1, 0, 1, 0, "R5");
      step(0, 0, 0, 0, "R5");
      step(1, 0, 1, 0, "R5");

      // self refresh, early enable held off, then exit window with INHIBIT
      step(0, 6, 1, 0, "R3/R12");
      step(0, 2, 0, 1, "R9");
      step(0, 7, 0, 1, "R9");
      step(1, 3, 0, 1, "R8");
      step(1, 4, 1, 0, "R8");
      step(1, 1, 1, 0, "R8");
      step(1, 1, 1, 0, "R10/R12");
      step(0, 0, 1, 0, "R13");
      step(0, 1, 1, 0, "R13");
      step(1, 1, 1, 0, "R10");
      step(1, 0, 1, 0, "R10");
      step(1, 0, 1, 0, "R10");

      // self refresh exit with a forbidden command
      step(1, 0, 1, 0, "R11");
      step(0, 6, 1, 0, "R3");
      for (int i = 0; i < TRAS; i++) step(1, 0, 1, 0, "R8");
      step(1, 2, 1, 0, "R11");
      for (int i = 0; i < TXSR; i++) step(1, 0, 1, 0, "R11");
      step(0, 0, 1, 0, "R11");
      step(1, 0, 1, 0, "R11");

      // constrained random with periodic resets
      for (int blk = 0; blk < 8; blk++) begin
         do_reset();
         for (int k = 0; k < 500; k++) begin
            int  r, cm;
            logic c;
            r  = int'($urandom % 16);
            c  = ($urandom % 3) != 0;
            cm = (r < 6) ? 0 : (r < 8) ? 1 : (r < 11) ? 6 : int'($urandom % 8);
            step(c, cm, ($urandom % 4) != 0, ($urandom % 4) == 0, "mixed");
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule